// File: doc/BRIEF.md
# Wide Register Write Collector

This block stands between a 32-bit host write bus and a bank of internal registers that are wider than one bus beat. Host writes arrive one dword at a time. Writes to 128-bit registers and to 64-bit SRAM words are gathered in a single holding buffer. The full word is handed to the register bank only once every dword of that word has arrived. The buffer keeps a valid bit per dword lane, the aligned target address and the kind of target. This means partial writes to two different registers cannot be mixed into one commit.

Two write-only descriptor-pointer registers follow their own rules. A write to their top dword always commits. If the lower three dwords are not all held for that register, they are committed as zero. A write to one of their lower dwords is discarded while the buffer is busy with another register. Plain 32-bit registers skip the buffer. One of them, the timer command register of page 0, empties the buffer when written.

Every register repeats per page at a stride of 0x2000 bytes. The page number forms the upper address bits and is carried unchanged into the commit address. Each commit appears as a one-cycle pulse on the commit port, one clock after the accepted write that caused it. The register bank consumes that pulse directly.

The write port is valid/ready. `wr_ready` is held high at all times, so the host never sees back-pressure, and a write is accepted on every clock edge where `wr_valid` is high. The commit port is a plain strobe with no ready, because the register bank below always accepts it.

Top module: `wide_write_collector`

## Requirements
- R1: After reset, `commit_valid` is low and the buffer holds no lanes, so a single partial write to a wide register produces no commit.
- R2: `wr_ready` is always high. Each accepted write produces at most one commit, and it appears on the clock edge after the write is accepted. With `wr_valid` low, nothing commits.
- R3: Page offsets 0x000–0x0FF are ordinary 128-bit registers, 16-byte aligned. Dword lane i sits at byte offset 4·i. Once all four lanes of one register have been written, in any order, a commit is made with kind 2, the register's aligned address, and lane i in `commit_data` bits 32·i+31 down to 32·i. The buffer is then empty.
- R4: A write to an ordinary register or SRAM word other than the one the buffer is filling throws away the earlier partial lanes and starts filling for the new target.
- R5: Page offsets 0x1000–0x1FFF are 64-bit SRAM words, 8-byte aligned, with two lanes. Once both lanes are written, a commit is made with kind 1, the word's aligned address, the word in bits 63:0, and zeros in bits 127:64.
- R6: Page offsets 0x400 and 0x420 are plain 32-bit registers. A write to either commits with kind 0, the exact write address, the data in bits 31:0 and zeros above. Apart from R9, the buffer is left untouched.
- R7: The descriptor pointers are at page offsets 0x830 and 0xA10. A write to the top dword (offset +0xC) always commits, with kind 3 and the pointer's aligned address. The low 96 bits come from the buffer only if it holds lanes 0, 1 and 2 of that same pointer; otherwise they are zero. If the buffer held that pointer, it is emptied.
- R8: A write to lane 0, 1 or 2 of a descriptor pointer while the buffer holds lanes of any other target is discarded, and the buffer state does not change. If the buffer is empty or holds the same pointer, the lane is collected.
- R9: A write to offset 0x420 of page 0 empties the buffer. The same offset on any other page does not.
- R10: The byte address is page·0x2000 + offset. Registers at the same offset on different pages are distinct targets, and the page bits appear in `commit_addr`.
- R11: Writes to unmapped offsets, and writes whose address bits 1:0 are not zero, produce no commit and leave the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write accepted; always high |
| wr_addr | input | 15 | Byte address: page in bits 14:13, offset in 12:0 |
| wr_data | input | 32 | Write dword |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_kind | output | 2 | 0 plain, 1 SRAM word, 2 wide register, 3 descriptor pointer |
| commit_addr | output | 15 | Aligned byte address of the committed target |
| commit_data | output | 128 | Committed value, lane 0 in bits 31:0 |

## Verification
The assertions rely on every input being a known value whenever `wr_valid` is high. They also rely on reset being held low across at least one rising edge before the first write. The stimulus respects both: it drives every input from time zero and changes them only on falling edges. It draws addresses from a few pages and only two registers per region, so restarts, dropped pointer writes and flushes from the timer register happen often. Directed sequences cover each collection and discard rule, with the expected commit worked out independently in the bench.

// File: rtl/wwc_pkg.sv
package wwc_pkg;

  // Classification of one host write after address decode
  typedef enum logic [2:0] {
    AC_NONE  = 3'd0,
    AC_PLAIN = 3'd1,
    AC_WIDE  = 3'd2,
    AC_SRAM  = 3'd3,
    AC_DESC  = 3'd4
  } acc_class_e;

  // Commit kind as seen on the commit port
  typedef enum logic [1:0] {
    CK_PLAIN = 2'd0,
    CK_SRAM  = 2'd1,
    CK_WIDE  = 2'd2,
    CK_DESC  = 2'd3
  } commit_kind_e;

  // In-page offsets
  localparam int unsigned WIDE_LIMIT  = 32'h100;
  localparam int unsigned OFS_EVENT   = 32'h400;
  localparam int unsigned OFS_TIMER   = 32'h420;
  localparam int unsigned OFS_PTR_A   = 32'h830;
  localparam int unsigned OFS_PTR_B   = 32'hA10;
  localparam int unsigned SRAM_LO     = 32'h1000;
  localparam int unsigned SRAM_HI     = 32'h1FFF;

  localparam int LANES     = 4;
  localparam int LANE_W    = 32;
  localparam int WORD_W    = LANES * LANE_W;

endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
  import wwc_pkg::*;
#(
  parameter int PAGE_BITS   = 2,
  parameter int STRIDE_LOG2 = 13,
  localparam int AW = PAGE_BITS + STRIDE_LOG2
) (
  input  logic [AW-1:0] addr,
  output acc_class_e    cls,
  output logic [1:0]    lane,
  output logic [AW-1:0] base,
  output logic          flush
);

  logic [31:0] ofs32;
  logic        page_zero;
  logic        aligned;

  assign ofs32     = {{(32-STRIDE_LOG2){1'b0}}, addr[STRIDE_LOG2-1:0]};
  assign page_zero = (addr[AW-1:STRIDE_LOG2] == '0);
  assign aligned   = (addr[1:0] == 2'b00);

  always_comb begin
    cls   = AC_NONE;
    lane  = addr[3:2];
    base  = {addr[AW-1:4], 4'b0000};
    flush = 1'b0;
    if (aligned) begin
      if (ofs32 < WIDE_LIMIT) begin
        cls = AC_WIDE;
      end else if (ofs32 == OFS_EVENT || ofs32 == OFS_TIMER) begin
        cls   = AC_PLAIN;
        lane  = 2'd0;
        base  = addr;
        flush = (ofs32 == OFS_TIMER) && page_zero;
      end else if ((ofs32 & ~32'hF) == OFS_PTR_A || (ofs32 & ~32'hF) == OFS_PTR_B) begin
        cls = AC_DESC;
      end else if (ofs32 >= SRAM_LO && ofs32 <= SRAM_HI) begin
        cls  = AC_SRAM;
        lane = {1'b0, addr[2]};
        base = {addr[AW-1:3], 3'b000};
      end
    end
  end

endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
  import wwc_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  acc_class_e        cls,
  input  logic [1:0]        lane,
  input  logic [AW-1:0]     base,
  input  logic              flush,
  input  logic [LANE_W-1:0] wdata,
  output logic              cmt_req,
  output commit_kind_e      cmt_kind,
  output logic [AW-1:0]     cmt_addr,
  output logic [WORD_W-1:0] cmt_data
);

  logic [LANES-1:0]  col_valid, nxt_valid;
  logic [AW-1:0]     col_base, nxt_base;
  acc_class_e        col_kind, nxt_kind;
  logic [LANE_W-1:0] col_data [LANES];

  logic [LANES-1:0]  lane_bit;
  logic [LANES-1:0]  lane_we;
  logic [LANES-1:0]  merged;
  logic [LANES-1:0]  need_mask;
  logic [LANE_W-1:0] lv [LANES];
  logic              hit, empty, dropped;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_bit[g] = (lane == 2'(g));
      assign lv[g]       = lane_bit[g] ? wdata : col_data[g];
    end
  endgenerate

  assign empty     = (col_valid == '0);
  assign hit       = !empty && (col_base == base) && (col_kind == cls);
  assign merged    = (hit ? col_valid : '0) | lane_bit;
  assign need_mask = (cls == AC_WIDE) ? 4'hF : 4'h3;

  always_comb begin
    nxt_valid = col_valid;
    nxt_base  = col_base;
    nxt_kind  = col_kind;
    lane_we   = '0;
    cmt_req   = 1'b0;
    cmt_kind  = CK_PLAIN;
    cmt_addr  = base;
    cmt_data  = '0;
    dropped   = 1'b0;
    if (fire) begin
      unique case (cls)
        AC_PLAIN: begin
          cmt_req  = 1'b1;
          cmt_data = {96'b0, wdata};
          if (flush) nxt_valid = '0;
        end
        AC_WIDE, AC_SRAM: begin
          if (merged == need_mask) begin
            cmt_req   = 1'b1;
            cmt_kind  = (cls == AC_WIDE) ? CK_WIDE : CK_SRAM;
            cmt_data  = (cls == AC_WIDE) ? {lv[3], lv[2], lv[1], lv[0]}
                                         : {64'b0, lv[1], lv[0]};
            nxt_valid = '0;
          end else begin
            nxt_valid = merged;
            nxt_base  = base;
            nxt_kind  = cls;
            lane_we   = lane_bit;
          end
        end
        AC_DESC: begin
          if (lane == 2'd3) begin
            cmt_req  = 1'b1;
            cmt_kind = CK_DESC;
            cmt_data = (hit && col_valid[2:0] == 3'b111)
                     ? {wdata, col_data[2], col_data[1], col_data[0]}
                     : {wdata, 96'b0};
            if (hit) nxt_valid = '0;
          end else if (empty || hit) begin
            nxt_valid = merged;
            nxt_base  = base;
            nxt_kind  = AC_DESC;
            lane_we   = lane_bit;
          end else begin
            dropped = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= '0;
      col_base  <= '0;
      col_kind  <= AC_NONE;
      for (int i = 0; i < LANES; i++) col_data[i] <= '0;
    end else begin
      col_valid <= nxt_valid;
      col_base  <= nxt_base;
      col_kind  <= nxt_kind;
      for (int i = 0; i < LANES; i++)
        if (lane_we[i]) col_data[i] <= wdata;
    end
  end

  // R3: a wide commit completes a register that already held three lanes
  p_wide_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_req && cmt_kind == CK_WIDE |-> $countones(col_valid) == 3);

  // R5: an SRAM commit completes a word that already held one lane
  p_sram_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_req && cmt_kind == CK_SRAM |-> $countones(col_valid) == 1);

  // R6: plain writes outside the flush case leave the buffer alone
  p_plain_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cls == AC_PLAIN && !flush |=> $stable(col_valid) && $stable(col_base));

  // R8: a discarded pointer write keeps the buffer state
  p_drop_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> $stable(col_valid) && $stable(col_base) && $stable(col_kind));

  // R9: the timer command on page 0 empties the buffer
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cls == AC_PLAIN && flush |=> col_valid == '0);

  // R11: unmapped writes change nothing
  p_unmapped_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cls == AC_NONE |=> $stable(col_valid) && $stable(col_base));

endmodule

// File: rtl/wwc_commit_stage.sv
module wwc_commit_stage
  import wwc_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_req,
  input  commit_kind_e      cmt_kind,
  input  logic [AW-1:0]     cmt_addr,
  input  logic [WORD_W-1:0] cmt_data,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [AW-1:0]     out_addr,
  output logic [WORD_W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= cmt_req;
      if (cmt_req) begin
        out_kind <= cmt_kind;
        out_addr <= cmt_addr;
        out_data <= cmt_data;
      end
    end
  end

endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import wwc_pkg::*;
#(
  parameter int PAGE_BITS   = 2,
  parameter int STRIDE_LOG2 = 13,
  localparam int AW = PAGE_BITS + STRIDE_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  output logic              commit_valid,
  output logic [1:0]        commit_kind,
  output logic [AW-1:0]     commit_addr,
  output logic [127:0]      commit_data
);

  acc_class_e        d_cls;
  logic [1:0]        d_lane;
  logic [AW-1:0]     d_base;
  logic              d_flush;
  logic              fire;
  logic              c_req;
  commit_kind_e      c_kind;
  logic [AW-1:0]     c_addr;
  logic [WORD_W-1:0] c_data;

  assign wr_ready = 1'b1;
  assign fire     = wr_valid && wr_ready;

  wwc_decode #(.PAGE_BITS(PAGE_BITS), .STRIDE_LOG2(STRIDE_LOG2)) u_decode (
    .addr  (wr_addr),
    .cls   (d_cls),
    .lane  (d_lane),
    .base  (d_base),
    .flush (d_flush)
  );

  wwc_collector #(.AW(AW)) u_collector (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .cls      (d_cls),
    .lane     (d_lane),
    .base     (d_base),
    .flush    (d_flush),
    .wdata    (wr_data),
    .cmt_req  (c_req),
    .cmt_kind (c_kind),
    .cmt_addr (c_addr),
    .cmt_data (c_data)
  );

  wwc_commit_stage #(.AW(AW)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmt_req   (c_req),
    .cmt_kind  (c_kind),
    .cmt_addr  (c_addr),
    .cmt_data  (c_data),
    .out_valid (commit_valid),
    .out_kind  (commit_kind),
    .out_addr  (commit_addr),
    .out_data  (commit_data)
  );

  // R2: a commit only follows an accepted write
  p_commit_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(wr_valid));

  // R5: SRAM commits carry zeros above bit 63
  p_sram_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && commit_kind == 2'd1 |-> commit_data[127:64] == '0);

  // R6: plain commits carry zeros above bit 31
  p_plain_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && commit_kind == 2'd0 |-> commit_data[127:32] == '0);

endmodule

// File: tb/wide_write_collector_tb.sv
`timescale 1ns/1ps
module wide_write_collector_tb_top;

  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          commit_valid;
  logic [1:0]    commit_kind;
  logic [AW-1:0] commit_addr;
  logic [127:0]  commit_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wide_write_collector dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit_valid(commit_valid),
    .commit_kind(commit_kind), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  // Reference state, written from the requirements
  logic [3:0]    mv;
  logic [31:0]   md [4];
  logic [AW-1:0] mb;
  int            mk;

  // 0 none, 1 plain, 2 wide, 3 sram, 4 pointer
  function automatic int classify(input logic [AW-1:0] a);
    int ofs;
    ofs = int'(a[12:0]);
    if (a[1:0] != 2'b00) return 0;
    if (ofs < 'h100) return 2;
    if (ofs == 'h400 || ofs == 'h420) return 1;
    if ((ofs >= 'h830 && ofs <= 'h83C) || (ofs >= 'hA10 && ofs <= 'hA1C)) return 4;
    if (ofs >= 'h1000) return 3;
    return 0;
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      1: return "R6";
      2: return "R3";
      3: return "R5";
      4: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input logic [AW-1:0] a, input logic [31:0] d,
                       output logic ev, output logic [1:0] ek,
                       output logic [AW-1:0] ea, output logic [127:0] ed);
    int c, ln;
    logic [AW-1:0] b;
    bit same;
    c  = classify(a);
    ev = 0; ek = 0; ea = '0; ed = '0;
    b  = (c == 3) ? {a[AW-1:3], 3'b0} : {a[AW-1:4], 4'b0};
    ln = (c == 3) ? int'(a[2]) : int'(a[3:2]);
    same = (mv != 0) && (mb == b) && (mk == c);
    case (c)
      1: begin
        ev = 1; ek = 0; ea = a; ed = {96'b0, d};
        if (a[12:0] == 13'h420 && a[14:13] == 2'd0) mv = 0;
      end
      2, 3: begin
        if (!same) begin mv = 0; mb = b; mk = c; end
        mv[ln] = 1'b1; md[ln] = d;
        if ((c == 2 && mv == 4'hF) || (c == 3 && mv == 4'h3)) begin
          ev = 1; ea = b;
          ek = (c == 2) ? 2'd2 : 2'd1;
          ed = (c == 2) ? {md[3], md[2], md[1], md[0]} : {64'b0, md[1], md[0]};
          mv = 0;
        end
      end
      4: begin
        if (ln == 3) begin
          ev = 1; ek = 3; ea = b;
          ed = (same && mv[2:0] == 3'b111) ? {d, md[2], md[1], md[0]} : {d, 96'b0};
          if (same) mv = 0;
        end else if (mv == 0 || same) begin
          if (!same) begin mv = 0; mb = b; mk = 4; end
          mv[ln] = 1'b1; md[ln] = d;
        end
      end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic ev, input logic [1:0] ek,
                       input logic [AW-1:0] ea, input logic [127:0] ed);
    checks++;
    if (commit_valid !== ev || (ev && (commit_kind !== ek || commit_addr !== ea || commit_data !== ed))) begin
      errors++;
      $display("FAIL %s: got v=%b k=%0d a=%h d=%h, expected v=%b k=%0d a=%h d=%h",
               tag, commit_valid, commit_kind, commit_addr, commit_data, ev, ek, ea, ed);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    logic ev; logic [1:0] ek; logic [AW-1:0] ea; logic [127:0] ed;
    wr_valid = 1; wr_addr = a; wr_data = d;
    model(a, d, ev, ek, ea, ed);
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
    check((tag == "") ? tag_of(classify(a)) : tag, ev, ek, ea, ed);
  endtask

  task automatic idle();
    wr_valid = 0; wr_addr = AW'($urandom); wr_data = $urandom;
    @(posedge clk); @(negedge clk);
    check("R2", 1'b0, 2'd0, '0, '0);
  endtask

  function automatic logic [AW-1:0] mk_addr(input int pg, input int ofs);
    return AW'(pg * 'h2000 + ofs);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, got no end, expected end of stimulus");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mv = 0; mb = '0; mk = 0;
    for (int i = 0; i < 4; i++) md[i] = '0;
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1", 1'b0, 2'd0, '0, '0);
    wr(mk_addr(0, 'h00C), 32'hA0A0_0003, "R1");

    // R3: all four lanes out of order
    wr(mk_addr(0, 'h018), 32'h1111_0002, "R3");
    wr(mk_addr(0, 'h010), 32'h1111_0000, "R3");
    wr(mk_addr(0, 'h01C), 32'h1111_0003, "R3");
    wr(mk_addr(0, 'h014), 32'h1111_0001, "R3");
    // R4: restart on another register
    wr(mk_addr(0, 'h020), 32'h2222_0000, "R4");
    wr(mk_addr(0, 'h024), 32'h2222_0001, "R4");
    wr(mk_addr(0, 'h030), 32'h3333_0000, "R4");
    wr(mk_addr(0, 'h028), 32'h2222_0002, "R4");
    wr(mk_addr(0, 'h02C), 32'h2222_0003, "R4");
    idle();
    // R5: SRAM word
    wr(mk_addr(1, 'h100C), 32'h5555_0001, "R5");
    wr(mk_addr(1, 'h1008), 32'h5555_0000, "R5");
    // R6: plain write amid collection
    wr(mk_addr(0, 'h040), 32'h4444_0000, "R6");
    wr(mk_addr(0, 'h044), 32'h4444_0001, "R6");
    wr(mk_addr(0, 'h048), 32'h4444_0002, "R6");
    wr(mk_addr(1, 'h400), 32'h6666_0000, "R6");
    wr(mk_addr(0, 'h04C), 32'h4444_0003, "R6");
    // R7: full pointer, bare top, partial pointer
    wr(mk_addr(0, 'h830), 32'h7777_0000, "R7");
    wr(mk_addr(0, 'h834), 32'h7777_0001, "R7");
    wr(mk_addr(0, 'h838), 32'h7777_0002, "R7");
    wr(mk_addr(0, 'h83C), 32'h7777_0003, "R7");
    wr(mk_addr(0, 'hA1C), 32'h7878_0003, "R7");
    wr(mk_addr(0, 'h830), 32'h7979_0000, "R7");
    wr(mk_addr(0, 'h83C), 32'h7979_0003, "R7");
    // R8: lower pointer dword dropped while busy
    wr(mk_addr(0, 'h050), 32'h8888_0000, "R8");
    wr(mk_addr(0, 'h054), 32'h8888_0001, "R8");
    wr(mk_addr(0, 'hA14), 32'hDEAD_0001, "R8");
    wr(mk_addr(0, 'h058), 32'h8888_0002, "R8");
    wr(mk_addr(0, 'h05C), 32'h8888_0003, "R8");
    // R9: page-0 timer flushes, page-2 timer does not
    wr(mk_addr(0, 'h060), 32'h9999_0000, "R9");
    wr(mk_addr(0, 'h064), 32'h9999_0001, "R9");
    wr(mk_addr(0, 'h068), 32'h9999_0002, "R9");
    wr(mk_addr(0, 'h420), 32'h0000_0042, "R9");
    wr(mk_addr(0, 'h06C), 32'h9999_0003, "R9");
    wr(mk_addr(0, 'h060), 32'h9A9A_0000, "R9");
    wr(mk_addr(0, 'h064), 32'h9A9A_0001, "R9");
    wr(mk_addr(0, 'h068), 32'h9A9A_0002, "R9");
    wr(mk_addr(2, 'h420), 32'h0000_0043, "R9");
    wr(mk_addr(0, 'h06C), 32'h9A9A_0003, "R9");
    // R10: page 3 pointer, and same offset on another page is distinct
    wr(mk_addr(3, 'hA10), 32'hAAAA_0000, "R10");
    wr(mk_addr(3, 'hA14), 32'hAAAA_0001, "R10");
    wr(mk_addr(3, 'hA18), 32'hAAAA_0002, "R10");
    wr(mk_addr(3, 'hA1C), 32'hAAAA_0003, "R10");
    wr(mk_addr(1, 'h070), 32'hABAB_0000, "R10");
    wr(mk_addr(2, 'h074), 32'hABAB_0001, "R10");
    // R11: unmapped and misaligned in the middle of a collection
    wr(mk_addr(0, 'h080), 32'hBBBB_0000, "R11");
    wr(mk_addr(0, 'h084), 32'hBBBB_0001, "R11");
    wr(mk_addr(0, 'h600), 32'hDEAD_0600, "R11");
    wr(mk_addr(0, 'h08A), 32'hDEAD_008A, "R11");
    wr(mk_addr(0, 'h088), 32'hBBBB_0002, "R11");
    wr(mk_addr(0, 'h08C), 32'hBBBB_0003, "R11");

    // Random phase
    for (int n = 0; n < 400; n++) begin
      int r, pg, sel;
      r  = int'($urandom % 10);
      pg = int'($urandom % 4);
      sel = int'($urandom % 2);
      if (r <= 2) begin
        int c;
        c = int'($urandom % 3);
        if (c == 0) wr(mk_addr(pg, sel * 16 + int'($urandom % 4) * 4), $urandom, "");
        else if (c == 1) wr(mk_addr(pg, 'h1000 + sel * 8 + int'($urandom % 2) * 4), $urandom, "");
        else wr(mk_addr(pg, (sel ? 'hA10 : 'h830) + int'($urandom % 4) * 4), $urandom, "");
      end else if (r <= 5) begin
        int ord [4];
        int kind, nl, base_ofs;
        kind = int'($urandom % 3);
        nl = (kind == 1) ? 2 : 4;
        base_ofs = (kind == 0) ? sel * 16 : (kind == 1) ? 'h1000 + sel * 8 : (sel ? 'hA10 : 'h830);
        for (int i = 0; i < 4; i++) ord[i] = i;
        for (int i = nl - 1; i > 0; i--) begin
          int j, t;
          j = int'($urandom % (i + 1));
          t = ord[i]; ord[i] = ord[j]; ord[j] = t;
        end
        for (int i = 0; i < nl; i++) begin
          if ($urandom % 8 == 0) wr(mk_addr(int'($urandom % 4), ($urandom % 2) ? 'h420 : 'h400), $urandom, "");
          wr(mk_addr(pg, base_ofs + ord[i] * 4), $urandom, "");
        end
      end else if (r == 6) begin
        idle();
      end else if (r == 7) begin
        wr(mk_addr(pg, sel ? 'h420 : 'h400), $urandom, "");
      end else if (r == 8) begin
        wr(mk_addr(pg, sel ? 'h700 : 'h043), $urandom, "");
      end else begin
        wr(mk_addr(pg, sel ? 'hA1C : 'h83C), $urandom, "");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule